// File: doc/BRIEF.md
# Oversampling Accumulator with Round-Half-Up Shift

This block follows a successive-approximation converter core. Each conversion-done pulse brings one raw result, which the block adds into a running sum. After a programmable number N of results, where N is a power of two between 2 and 256, it rounds the sum to nearest and shifts it right by 0 to 8 bits. It keeps the low 16 bits of that value as the oversampled result.

Three flags pace the software or DMA side. A sampling flag pulses for every raw sample. A conversion flag pulses once per N samples, when a new result lands in the data register. A sequence flag pulses together with the conversion flag of the last channel in a scan, which is N times the scan length raw conversions after the scan began.

Reduced-resolution samples (10, 8 or 6 bits, zero-extended into the 12-bit input) go through the same arithmetic as full 12-bit samples. The result is always right-aligned. An abort discards the partial window. A result that is replaced before it has been read raises an overrun flag.

Top module: `osr_accum`

## Requirements
- R1: For each cycle with `conv_done` high and `abort` low, `eosmp` is high for exactly the following cycle.
- R2: `cfg_ratio` encodes N as 2 << code, so 0 gives 2x and 7 gives 256x. `eoc` is high for one cycle after every N-th accepted sample and low after every other sample.
- R3: The result is (sum + 2^(s-1)) >> s, with no bias when s = 0. The shift s is `cfg_shift` for codes 0 to 8; codes 9 to 15 act as 8.
- R4: Only the low 16 bits of the rounded, shifted value are kept. For example, 32 samples of 0xFFF with no shift read as 0xFFE0.
- R5: `data_out` is right-aligned and changes only in the cycle where `eoc` rises. It holds its value at all other times.
- R6: `cfg_chans` holds the scan length minus one. `eos` is high together with `eoc` only on the last channel's result, which comes after (cfg_chans+1)·N accepted samples.
- R7: `abort` clears the partial sum, the sample count and the channel position. A sample presented in the same cycle is dropped and `eoc` stays low. The next N samples form a fresh window at channel 0.
- R8: If a new result is written while the previous one is unread and `rd_strobe` is low in that cycle, `ovr` is set and `data_out` takes the new result. A `rd_strobe` with no new result clears both the unread state and `ovr`.
- R9: After reset, `data_out` is 0 and `eosmp`, `eoc`, `eos` and `ovr` are all low.
- R10: Reduced-resolution samples give exactly the sum-round-shift-truncate result of R3 and R4 computed on their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| abort | input | 1 | Discard the current window and the scan position |
| conv_done | input | 1 | One raw sample is valid on `conv_data` |
| conv_data | input | 12 | Raw conversion result, right-aligned |
| cfg_ratio | input | 3 | Oversampling ratio code, N = 2 << code |
| cfg_shift | input | 4 | Right shift code, 0 to 8 (larger codes act as 8) |
| cfg_chans | input | 4 | Channels per scan minus one |
| rd_strobe | input | 1 | The data register is being read |
| data_out | output | 16 | Oversampled result |
| eosmp | output | 1 | End-of-sampling pulse, one per sample |
| eoc | output | 1 | End-of-conversion pulse, one per N samples |
| eos | output | 1 | End-of-sequence pulse |
| ovr | output | 1 | Unread result was overwritten |

## Verification
A wrong sample count shows up in the very next window. `eoc` rises one sample early or late, and `data_out` is off by a whole sample. A corrupted partial sum appears as a wrong `data_out` at the end of the same window. Off-by-one rounding only shows with a sum whose discarded bits sit exactly at one half, so there are directed vectors for that case. Errors in the channel position or the unread state appear at the ports only at the next scan end or the next result, so `eos` and `ovr` are checked across several consecutive windows.

// File: rtl/osr_pkg.sv
// Package: shared sizing for the oversampling accumulator.
// Assumes the ratio code selects N = 2 << code, so the count width is 2**RATIO_W.
package osr_pkg;
    localparam int SAMPLE_W  = 12;
    localparam int RESULT_W  = 16;
    localparam int RATIO_W   = 3;
    localparam int SHIFT_W   = 4;
    localparam int MAX_SHIFT = 8;
    localparam int CHAN_W    = 4;

    // Width of a counter that reaches N-1 for the largest ratio.
    function automatic int cnt_width(input int ratio_w);
        return 1 << ratio_w;
    endfunction
endpackage

// File: rtl/osr_window_ctr.sv
// Module: osr_window_ctr
// Counts accepted samples inside one oversampling window and the channel
// position inside a scan. Assumes configuration is stable while a window runs.
module osr_window_ctr #(
    parameter int RATIO_W = 3,
    parameter int CHAN_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort,
    input  logic               conv_done,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic [CHAN_W-1:0]  cfg_chans,
    output logic               last_samp,
    output logic               last_chan
);
    localparam int CNT_W = osr_pkg::cnt_width(RATIO_W);

    logic [CNT_W-1:0]  samp_cnt;
    logic [CHAN_W-1:0] chan_cnt;
    logic [CNT_W:0]    n_val;

    // Decode the ratio code into the window length.
    always_comb begin
        n_val     = (CNT_W+1)'(2) << cfg_ratio;
        last_samp = ({1'b0, samp_cnt} == (n_val - 1'b1));
        last_chan = (chan_cnt == cfg_chans);
    end

    // Step the sample and channel counters on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            samp_cnt <= '0;
            chan_cnt <= '0;
        end else if (conv_done) begin
            if (last_samp) begin
                samp_cnt <= '0;
                chan_cnt <= last_chan ? '0 : chan_cnt + 1'b1;
            end else begin
                samp_cnt <= samp_cnt + 1'b1;
            end
        end
    end

    a_r2_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, samp_cnt} < n_val));
    a_r6_chan_in_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_cnt <= cfg_chans) || $past(cfg_chans) != cfg_chans);
endmodule

// File: rtl/osr_round_shift.sv
// Module: osr_round_shift
// Purely combinational: adds half of the dropped LSB weight to the sum,
// shifts right, and keeps the low OUT_W bits. Shift codes above MAX_SHIFT clamp.
module osr_round_shift #(
    parameter int IN_W      = 20,
    parameter int OUT_W     = 16,
    parameter int SHIFT_W   = 4,
    parameter int MAX_SHIFT = 8
) (
    input  logic [IN_W-1:0]    sum,
    input  logic [SHIFT_W-1:0] shift_code,
    output logic [OUT_W-1:0]   result
);
    logic [SHIFT_W-1:0] eff_shift;
    logic [IN_W:0]      bias;
    logic [IN_W:0]      rounded;
    logic [IN_W:0]      shifted;

    // Clamp the shift, bias by half an output LSB, shift and truncate.
    always_comb begin
        eff_shift = (shift_code > SHIFT_W'(MAX_SHIFT)) ? SHIFT_W'(MAX_SHIFT) : shift_code;
        bias      = (eff_shift == '0) ? '0 : ((IN_W+1)'(1) << (eff_shift - 1'b1));
        rounded   = {1'b0, sum} + bias;
        shifted   = rounded >> eff_shift;
        result    = OUT_W'(shifted);
    end

    a_r3_bias_below_half: assert final (eff_shift <= SHIFT_W'(MAX_SHIFT));
endmodule

// File: rtl/osr_result_reg.sv
// Module: osr_result_reg
// Holds the oversampled result and drives the sampling, conversion, sequence
// and overrun flags. Assumes win_done is already qualified by abort.
module osr_result_reg #(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_ok,
    input  logic             win_done,
    input  logic             seq_last,
    input  logic             rd_strobe,
    input  logic [OUT_W-1:0] result,
    output logic [OUT_W-1:0] data_out,
    output logic             eosmp,
    output logic             eoc,
    output logic             eos,
    output logic             ovr
);
    logic unread;

    // Register the flags and the data word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= '0;
            eosmp    <= 1'b0;
            eoc      <= 1'b0;
            eos      <= 1'b0;
        end else begin
            eosmp <= samp_ok;
            eoc   <= win_done;
            eos   <= win_done && seq_last;
            if (win_done) data_out <= result;
        end
    end

    // Track unread results and overwrite-before-read events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unread <= 1'b0;
            ovr    <= 1'b0;
        end else if (win_done) begin
            unread <= 1'b1;
            ovr    <= (unread && !rd_strobe) || (ovr && !rd_strobe);
        end else if (rd_strobe) begin
            unread <= 1'b0;
            ovr    <= 1'b0;
        end
    end

    a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && unread && !rd_strobe) |=> ovr);
    a_r5_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done |=> $stable(data_out));
endmodule

// File: rtl/osr_accum.sv
// Module: osr_accum (top)
// Sums N raw samples, rounds and shifts the total, and publishes a 16-bit
// right-aligned result with its flags. Assumes one sample at most per cycle.
module osr_accum #(
    parameter int SAMPLE_W  = osr_pkg::SAMPLE_W,
    parameter int RESULT_W  = osr_pkg::RESULT_W,
    parameter int RATIO_W   = osr_pkg::RATIO_W,
    parameter int SHIFT_W   = osr_pkg::SHIFT_W,
    parameter int MAX_SHIFT = osr_pkg::MAX_SHIFT,
    parameter int CHAN_W    = osr_pkg::CHAN_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                abort,
    input  logic                conv_done,
    input  logic [SAMPLE_W-1:0] conv_data,
    input  logic [RATIO_W-1:0]  cfg_ratio,
    input  logic [SHIFT_W-1:0]  cfg_shift,
    input  logic [CHAN_W-1:0]   cfg_chans,
    input  logic                rd_strobe,
    output logic [RESULT_W-1:0] data_out,
    output logic                eosmp,
    output logic                eoc,
    output logic                eos,
    output logic                ovr
);
    localparam int ACC_W = SAMPLE_W + osr_pkg::cnt_width(RATIO_W);

    logic [ACC_W-1:0]    acc;
    logic [ACC_W-1:0]    sum_total;
    logic [RESULT_W-1:0] result;
    logic                last_samp;
    logic                last_chan;
    logic                samp_ok;
    logic                win_done;

    osr_window_ctr #(.RATIO_W(RATIO_W), .CHAN_W(CHAN_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .abort(abort), .conv_done(conv_done),
        .cfg_ratio(cfg_ratio), .cfg_chans(cfg_chans),
        .last_samp(last_samp), .last_chan(last_chan)
    );

    // Qualify incoming samples and form the running total.
    always_comb begin
        samp_ok   = conv_done && !abort;
        win_done  = samp_ok && last_samp;
        sum_total = acc + ACC_W'(conv_data);
    end

    // Accumulate samples; restart after the window closes or on abort.
    always_ff @(posedge clk) begin
        if (!rst_n || abort)  acc <= '0;
        else if (samp_ok)     acc <= last_samp ? '0 : sum_total;
    end

    osr_round_shift #(.IN_W(ACC_W), .OUT_W(RESULT_W), .SHIFT_W(SHIFT_W),
                      .MAX_SHIFT(MAX_SHIFT)) u_round (
        .sum(sum_total), .shift_code(cfg_shift), .result(result)
    );

    osr_result_reg #(.OUT_W(RESULT_W)) u_out (
        .clk(clk), .rst_n(rst_n), .samp_ok(samp_ok), .win_done(win_done),
        .seq_last(last_chan), .rd_strobe(rd_strobe), .result(result),
        .data_out(data_out), .eosmp(eosmp), .eoc(eoc), .eos(eos), .ovr(ovr)
    );

    a_r7_abort_no_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !eoc);
    a_r6_eos_with_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        eos |-> eoc);
    a_r2_eoc_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> eosmp);
    a_r1_eosmp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !abort) |=> eosmp);
endmodule

// File: tb/osr_accum_test.sv
// Bench for osr_accum: a vector table walked by one loop, then directed tests.
module osr_accum_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        abort = 1'b0;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic [2:0]  cfg_ratio = '0;
    logic [3:0]  cfg_shift = '0;
    logic [3:0]  cfg_chans = '0;
    logic        rd_strobe = 1'b0;
    logic [15:0] data_out;
    logic        eosmp, eoc, eos, ovr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    osr_accum uut (
        .clk(clk), .rst_n(rst_n), .abort(abort), .conv_done(conv_done),
        .conv_data(conv_data), .cfg_ratio(cfg_ratio), .cfg_shift(cfg_shift),
        .cfg_chans(cfg_chans), .rd_strobe(rd_strobe), .data_out(data_out),
        .eosmp(eosmp), .eoc(eoc), .eos(eos), .ovr(ovr)
    );

    // Vector: {ratio[2:0], shift[3:0], sample[11:0], expected[15:0]}
    localparam int NV = 10;
    localparam logic [34:0] VEC [NV] = '{
        {3'd0, 4'd0,  12'hFFF, 16'h1FFE},  // R2 R3
        {3'd0, 4'd1,  12'hFFF, 16'h0FFF},  // R3
        {3'd0, 4'd2,  12'hFFF, 16'h0800},  // R3 rounding carry
        {3'd1, 4'd3,  12'hFFF, 16'h0800},  // R3
        {3'd3, 4'd4,  12'hFFF, 16'h0FFF},  // R3
        {3'd4, 4'd0,  12'hFFF, 16'hFFE0},  // R4 truncation
        {3'd7, 4'd0,  12'hFFF, 16'hFF00},  // R4 truncation 256x
        {3'd7, 4'd8,  12'hFFF, 16'h0FFF},  // R3 max shift
        {3'd2, 4'd0,  12'h3FF, 16'h1FF8},  // R10 10-bit samples
        {3'd5, 4'd5,  12'h03F, 16'h007E}   // R10 6-bit samples
    };

    // Compare one value and report a mismatch.
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Present one sample, then check the flags one cycle later.
    task automatic feed(input logic [11:0] v, input bit exp_eoc, input bit exp_eos);
        @(negedge clk);
        conv_done = 1'b1;
        conv_data = v;
        @(negedge clk);
        conv_done = 1'b0;
        check("R1 eosmp", 32'(eosmp), 32'd1);
        check("R2 eoc", 32'(eoc), 32'(exp_eoc));
        check("R6 eos", 32'(eos), 32'(exp_eos));
    endtask

    // Pulse the read strobe for one cycle.
    task automatic do_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 data", 32'(data_out), 32'd0);
        check("R9 flags", {28'd0, eosmp, eoc, eos, ovr}, 32'd0);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            int n;
            cfg_ratio = VEC[i][34:32];
            cfg_shift = VEC[i][31:28];
            cfg_chans = 4'd0;
            n = 2 << VEC[i][34:32];
            for (int k = 0; k < n; k++)
                feed(VEC[i][27:16], k == n - 1, k == n - 1);
            check("R3 R4 R10 data", 32'(data_out), 32'(VEC[i][15:0]));
            check("R8 no overrun", 32'(ovr), 32'd0);
            do_read();
        end

        // R3 round-half-up: 1 + 2 = 3, shift 1 gives 2
        cfg_ratio = 3'd0; cfg_shift = 4'd1;
        feed(12'd1, 1'b0, 1'b0);
        feed(12'd2, 1'b1, 1'b1);
        check("R3 half up", 32'(data_out), 32'd2);
        do_read();

        // R3 shift code 15 acts as 8: 0x1FFE -> 0x20
        cfg_shift = 4'd15;
        feed(12'hFFF, 1'b0, 1'b0);
        feed(12'hFFF, 1'b1, 1'b1);
        check("R3 clamp", 32'(data_out), 32'h20);
        do_read();

        // R5 data holds between results
        cfg_shift = 4'd0;
        feed(12'd9, 1'b0, 1'b0);
        check("R5 hold", 32'(data_out), 32'h20);

        // R7 abort mid-window, also with a sample in the same cycle
        @(negedge clk);
        abort = 1'b1; conv_done = 1'b1; conv_data = 12'hFFF;
        @(negedge clk);
        abort = 1'b0; conv_done = 1'b0;
        check("R7 no eoc", 32'(eoc), 32'd0);
        check("R7 no eosmp", 32'(eosmp), 32'd0);
        check("R7 data kept", 32'(data_out), 32'h20);
        feed(12'd3, 1'b0, 1'b0);
        feed(12'd4, 1'b1, 1'b1);
        check("R7 fresh window", 32'(data_out), 32'd7);
        do_read();

        // R6 scan of three channels at 2x: eos only on the sixth sample
        cfg_chans = 4'd2;
        for (int c = 0; c < 3; c++) begin
            feed(12'd1, 1'b0, 1'b0);
            feed(12'd1, 1'b1, c == 2);
            do_read();
        end

        // R7 abort resets scan position (two channels)
        cfg_chans = 4'd1;
        feed(12'd1, 1'b0, 1'b0);
        feed(12'd1, 1'b1, 1'b0);
        do_read();
        @(negedge clk); abort = 1'b1;
        @(negedge clk); abort = 1'b0;
        feed(12'd1, 1'b0, 1'b0);
        feed(12'd1, 1'b1, 1'b0);  // R7 channel 0 again, no eos
        do_read();
        feed(12'd1, 1'b0, 1'b0);
        feed(12'd1, 1'b1, 1'b1);
        do_read();

        // R8 overrun: two results with no read in between
        cfg_chans = 4'd0;
        feed(12'd5, 1'b0, 1'b0);
        feed(12'd5, 1'b1, 1'b1);
        check("R8 first no ovr", 32'(ovr), 32'd0);
        feed(12'd7, 1'b0, 1'b0);
        feed(12'd7, 1'b1, 1'b1);
        check("R8 ovr set", 32'(ovr), 32'd1);
        check("R8 overwrite", 32'(data_out), 32'd14);
        do_read();
        check("R8 ovr cleared", 32'(ovr), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: end a hung run as a failure.
    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule